// File: doc/BRIEF.md
# Synchronous Serial Transmit Channel with Sample FIFO

This block is one transmit lane of a synchronous serial port. The host places 16-bit samples into a single holding register. With buffering switched on, each sample moves from the holding register into an eight-entry queue, and the serializer takes its words from the head of that queue. With buffering switched off, the queue is skipped and the serializer takes the holding register directly. The bit clock and frame sync come from outside the block as a one-cycle `bit_tick` enable and a `fsync` level in the system clock domain. `fsync` is only looked at on cycles where `bit_tick` is high.

Each word is left-justified in 16 bits. Only the top 8, 10, 12 or 16 bits are sent, and they go out either most-significant first or least-significant first. The serializer has two states:
- `ST_IDLE`: the line is held low. A tick with `fsync` high loads a word and moves to `ST_SHIFT` (transition IDLE_TO_SHIFT).
- `ST_SHIFT`: a tick with `fsync` high sends the next bit. If the word is already finished, it loads the following word back-to-back instead (transition SHIFT_HOLD). A tick with `fsync` low drops the rest of the word and returns to `ST_IDLE` (transition SHIFT_TO_IDLE).

An interrupt request asks for more data while the holding register is empty and the queue level is below a programmable threshold.

Top module: `ssi_tx_channel`

## Requirements
- R1: After reset, `sdo`=0, `irq`=0, `underrun`=0, `hold_empty`=1 and `fifo_level`=0.
- R2: A cycle with `wr_en`=1 puts `wr_data` into the holding register (`hold_empty`=0 after that edge). With `fifo_en`=1, a full holding register whose queue has fewer than 8 entries moves into the queue on the next edge: `fifo_level` rises by one and `hold_empty` returns to 1 unless a new write lands in the same cycle.
- R3: The queue holds 8 words in first-in first-out order. When the queue holds 8 words and the holding register is full, a new write replaces the holding register contents, and the queue is unchanged.
- R4: With `fifo_en`=0, a word load takes the holding register directly and empties it. Queue contents are left untouched.
- R5: `word_len` selects the number of bits per word: 0 selects 8, 1 selects 10, 2 selects 12 and 3 selects 16. The sent bits are the top bits of the 16-bit sample. The length is captured when the word is loaded.
- R6: With `lsb_first`=0, bits go out from bit 15 downward. With `lsb_first`=1, they go out from bit (16 minus length) upward to bit 15. The direction is captured at load.
- R7: A word loads on a `bit_tick` with `fsync`=1 while idle, or on such a tick after the last bit of the current word. Each later `bit_tick` with `fsync`=1 puts the next bit on `sdo` one edge after the tick. A `bit_tick` with `fsync`=0 abandons the word and returns to idle.
- R8: `sdo` is 0 whenever no word is being shifted.
- R9: If a word load finds no data, an all-zero word is sent and `underrun` is 1 from that load until the next load that finds data. A load finds no data when the queue is empty (`fifo_en`=1) or the holding register is empty (`fifo_en`=0).
- R10: `irq` = `int_en` AND `hold_empty` AND (`fifo_level` < `fifo_thresh`), evaluated combinationally on the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 16 | Sample written by the host, left-justified |
| fifo_en | input | 1 | 1 routes samples through the queue, 0 bypasses it |
| word_len | input | 2 | Bits per word: 0=8, 1=10, 2=12, 3=16 |
| lsb_first | input | 1 | 0 sends MSB first, 1 sends LSB first |
| int_en | input | 1 | Enables the transmit interrupt request |
| fifo_thresh | input | 3 | Interrupt threshold compared with the queue level |
| bit_tick | input | 1 | One-cycle bit clock enable |
| fsync | input | 1 | Frame sync level, sampled on `bit_tick` |
| sdo | output | 1 | Serial data out |
| hold_empty | output | 1 | Holding register is empty |
| fifo_level | output | 4 | Number of words in the queue (0 to 8) |
| irq | output | 1 | Transmit interrupt request |
| underrun | output | 1 | The word being sent is an all-zero fill word |

## Verification
The bench targets the following corner cases:
- A write into a full holding register with a full queue. A design that dropped the write would send the stale sample.
- LSB-first order at short word lengths. A design that started at bit 0 instead of bit (16 minus length) would send the ignored low bits.
- A frame sync that drops in the middle of a word. A design that kept shifting would leak bits into the gap.
- A word load with the queue empty but the holding register full in buffered mode. This must produce an underrun, because the sample only reaches the queue on that same edge.

The interrupt threshold is swept across every value, including 0, which must never raise a request.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;
    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        WL_8  = 2'd0,
        WL_10 = 2'd1,
        WL_12 = 2'd2,
        WL_16 = 2'd3
    } wlen_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } shstate_e;

    function automatic logic [CNT_W:0] wl_bits(input wlen_e code);
        unique case (code)
            WL_8:    wl_bits = (CNT_W+1)'(8);
            WL_10:   wl_bits = (CNT_W+1)'(10);
            WL_12:   wl_bits = (CNT_W+1)'(12);
            default: wl_bits = (CNT_W+1)'(16);
        endcase
    endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo
    import ssi_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] din,
    input  logic              pop,
    output logic [WORD_W-1:0] dout,
    output logic [LW-1:0]     level
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    assign dout = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R3: the queue never takes a word when it already holds DEPTH
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level < LW'(DEPTH)));

    // R2: a word is only taken from a non-empty queue
    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import ssi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              load_ok,
    input  logic [WORD_W-1:0] load_word,
    input  logic [1:0]        word_len,
    input  logic              lsb_first,
    output logic              take,
    output logic              sdo,
    output logic              underrun
);
    shstate_e          state, state_n;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  left;
    logic              dir;
    logic [CNT_W:0]    nbits;
    logic [CNT_W:0]    skip;
    logic [WORD_W-1:0] src, src_al;

    always_comb begin
        nbits  = wl_bits(wlen_e'(word_len));
        skip   = (CNT_W+1)'(WORD_W) - nbits;
        src    = load_ok ? load_word : '0;
        src_al = lsb_first ? (src >> skip) : src;
        take   = bit_tick && fsync && ((state == ST_IDLE) || (left == '0));
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (bit_tick && fsync)  state_n = ST_SHIFT;
            ST_SHIFT: if (bit_tick && !fsync) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg     <= '0;
            left     <= '0;
            dir      <= 1'b0;
            sdo      <= 1'b0;
            underrun <= 1'b0;
        end else if (take) begin
            dir      <= lsb_first;
            underrun <= !load_ok;
            left     <= CNT_W'(nbits - 1'b1);
            sdo      <= lsb_first ? src_al[0] : src_al[WORD_W-1];
            sreg     <= lsb_first ? (src_al >> 1) : (src_al << 1);
        end else if (bit_tick && fsync && (state == ST_SHIFT)) begin
            sdo  <= dir ? sreg[0] : sreg[WORD_W-1];
            sreg <= dir ? (sreg >> 1) : (sreg << 1);
            left <= left - 1'b1;
        end else if (bit_tick && !fsync) begin
            sdo  <= 1'b0;
            left <= '0;
        end
    end

    // R8: the line is quiet whenever the serializer is idle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdo);

    // R9: a fill word carries only zeros
    p_fill_is_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !sdo);
endmodule

// File: rtl/ssi_tx_channel.sv
module ssi_tx_channel
    import ssi_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fifo_en,
    input  logic [1:0]        word_len,
    input  logic              lsb_first,
    input  logic              int_en,
    input  logic [AW-1:0]     fifo_thresh,
    input  logic              bit_tick,
    input  logic              fsync,
    output logic              sdo,
    output logic              hold_empty,
    output logic [LW-1:0]     fifo_level,
    output logic              irq,
    output logic              underrun
);
    logic              hold_v;
    logic [WORD_W-1:0] hold_d;
    logic              push, pop, take, load_ok, bypass_take;
    logic [WORD_W-1:0] fifo_dout, load_word;

    always_comb begin
        push        = fifo_en && hold_v && (fifo_level < LW'(DEPTH));
        load_ok     = fifo_en ? (fifo_level != '0) : hold_v;
        load_word   = fifo_en ? fifo_dout : hold_d;
        pop         = take && fifo_en && (fifo_level != '0);
        bypass_take = take && !fifo_en && hold_v;
        hold_empty  = !hold_v;
        irq         = int_en && !hold_v && (fifo_level < {1'b0, fifo_thresh});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (wr_en) begin
            hold_v <= 1'b1;
            hold_d <= wr_data;
        end else if (push || bypass_take) begin
            hold_v <= 1'b0;
        end
    end

    sertx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (hold_d),
        .pop   (pop),
        .dout  (fifo_dout),
        .level (fifo_level)
    );

    sertx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .fsync     (fsync),
        .load_ok   (load_ok),
        .load_word (load_word),
        .word_len  (word_len),
        .lsb_first (lsb_first),
        .take      (take),
        .sdo       (sdo),
        .underrun  (underrun)
    );

    // R2/R3: any write leaves the holding register full after the edge
    p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R10: a request is only raised while the holding register is empty
    p_irq_needs_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hold_empty);
endmodule

// File: tb/sim_ssi_tx_channel.sv
module sim_ssi_tx_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fifo_en = 1'b1;
    logic [1:0]  word_len = 2'd3;
    logic        lsb_first = 1'b0;
    logic        int_en = 1'b0;
    logic [2:0]  fifo_thresh = 3'd0;
    logic        bit_tick = 1'b0;
    logic        fsync = 1'b0;
    logic        sdo, hold_empty, irq, underrun;
    logic [3:0]  fifo_level;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    ssi_tx_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .word_len(word_len), .lsb_first(lsb_first),
        .int_en(int_en), .fifo_thresh(fifo_thresh), .bit_tick(bit_tick),
        .fsync(fsync), .sdo(sdo), .hold_empty(hold_empty),
        .fifo_level(fifo_level), .irq(irq), .underrun(underrun)
    );

    // behavioural reference model
    logic [15:0] m_q[$];
    bit          m_bits[$];
    bit          m_hv, m_busy, m_sdo, m_under;
    logic [15:0] m_hd;

    function automatic int len_of(input logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 10 : (c == 2'd2) ? 12 : 16;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.delete(); m_bits.delete();
            m_hv = 0; m_hd = '0; m_busy = 0; m_sdo = 0; m_under = 0;
        end else begin
            automatic int  size0 = m_q.size();
            automatic bit  push = fifo_en && m_hv && (size0 < 8);
            automatic bit  byp  = 0;
            automatic logic [15:0] old_hd = m_hd;
            if (bit_tick) begin
                if (fsync && (!m_busy || m_bits.size() == 0)) begin
                    automatic bit avail = fifo_en ? (size0 > 0) : m_hv;
                    automatic logic [15:0] w = '0;
                    automatic int n = len_of(word_len);
                    if (avail) w = fifo_en ? m_q[0] : m_hd;
                    if (avail && fifo_en) void'(m_q.pop_front());
                    if (avail && !fifo_en) byp = 1;
                    m_under = !avail;
                    m_bits.delete();
                    for (int i = 0; i < n; i++)
                        m_bits.push_back(lsb_first ? w[16-n+i] : w[15-i]);
                    m_sdo = m_bits.pop_front();
                    m_busy = 1;
                end else if (m_busy && fsync) begin
                    m_sdo = m_bits.pop_front();
                end else if (!fsync) begin
                    m_busy = 0; m_sdo = 0; m_bits.delete();
                end
            end
            if (push) m_q.push_back(old_hd);
            if (wr_en) begin m_hv = 1; m_hd = wr_data; end
            else if (push || byp) m_hv = 0;
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
                     cur_req, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        cmp("sdo", sdo, m_sdo);
        cmp("hold_empty", hold_empty, !m_hv);
        cmp("fifo_level", fifo_level, m_q.size());
        cmp("underrun", underrun, m_under);
        cmp("irq", irq, int_en && !m_hv && (m_q.size() < fifo_thresh));
    endtask

    // one cycle: compare at the falling edge, then drive new inputs
    task automatic step(input bit wr, input bit fs, input int tick_per);
        @(negedge clk);
        cyc++;
        compare_all();
        wr_en    = wr;
        wr_data  = 16'($urandom);
        fsync    = fs;
        bit_tick = (cyc % tick_per) == 0;
    endtask

    task automatic run(input int n, input int wr_pct, input int fs_pct, input int tick_per);
        for (int i = 0; i < n; i++)
            step(($urandom % 100) < wr_pct, ($urandom % 100) < fs_pct, tick_per);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1 sdo", sdo, 0);
        cmp("R1 irq", irq, 0);
        cmp("R1 underrun", underrun, 0);
        cmp("R1 hold_empty", hold_empty, 1);
        cmp("R1 level", fifo_level, 0);
        rst_n = 1'b1;

        // R2: single write travels into the queue
        cur_req = "R2";
        step(1, 0, 1000);
        step(0, 0, 1000);
        cmp("R2 level after move", fifo_level, 0);
        step(0, 0, 1000);
        cmp("R2 level one", fifo_level, 1);
        cmp("R2 hold empty again", hold_empty, 1);

        // R3: fill queue and overwrite the holding register
        cur_req = "R3";
        for (int i = 0; i < 12; i++) step(1, 0, 1000);
        step(0, 0, 1000);
        cmp("R3 queue full", fifo_level, 8);
        cmp("R3 holding full", hold_empty, 0);

        // R7: continuous frame, drain at 16 bits MSB first
        cur_req = "R7";
        run(500, 0, 100, 3);

        // R5 / R6: every length in both orders
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l < 4; l++) begin
                cur_req = (d == 0) ? "R5" : "R6";
                word_len = 2'(l);
                lsb_first = d[0];
                run(220, 10, 100, 3);
            end
        end

        // R9: starve the queue
        cur_req = "R9";
        word_len = 2'd3; lsb_first = 1'b0;
        run(900, 0, 100, 2);
        cmp("R9 underrun flag", underrun, 1);

        // R4: bypass mode
        cur_req = "R4";
        fifo_en = 1'b0;
        run(600, 4, 100, 3);
        run(400, 8, 100, 2);

        // R7: frame sync dropping mid-word
        cur_req = "R7";
        fifo_en = 1'b1;
        run(800, 15, 70, 2);

        // R8: idle line
        cur_req = "R8";
        run(60, 0, 0, 2);
        cmp("R8 idle sdo", sdo, 0);

        // R10: threshold sweep
        cur_req = "R10";
        int_en = 1'b1;
        for (int t = 0; t < 8; t++) begin
            fifo_thresh = 3'(t);
            run(150, 12, 100, 2);
        end
        int_en = 1'b0;
        run(50, 20, 100, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule